// File: doc/BRIEF.md
# Countdown Core Timer

This block is a 32-bit down-counting timer that software drives through four word-wide registers on a plain memory-mapped bus. The registers hold a control word, a reload period, a prescale ratio and the live count. When the control word has both its power bit and its enable bit set, a prescaler divides the clock and each prescaler tick takes one off the count.

The count reaching zero is the expiry event. Expiry sets a sticky flag that reads back inside the control word and drives the single interrupt request output. It can also reload the count from the period register when auto-reload is selected. Software clears the flag by writing a one to the flag bit. Writing zero to the control word powers the timer down and stops counting.

A typical sequence loads period, scale and count first, and then writes the control word to start. Software then either polls the control word or waits for the interrupt.

Top module: `ctimer_top`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and the interrupt output is 0.
- R2: Word offsets select the registers: 0x0 control, 0x4 period, 0x8 scale, 0xC count. Period, scale and count read back what was written. Control reads back bits 0 (power), 1 (enable), 2 (auto-reload) and 3 (expiry flag), with all other bits 0.
- R3: The count changes only through a count write unless power (bit 0) and enable (bit 1) are both 1.
- R4: With scale S, a running timer decrements once every S+1 clock cycles, counted from the first cycle after the control write that starts it. Starting from count C, the flag sets on the C*(S+1)-th clock edge after that write's edge (for example S=1 or S=3 with C=2).
- R5: Expiry is the tick that takes the count from 1 to 0. It sets control bit 3. With power and enable on and auto-reload off, control then reads 0x0000000B, the count rests at 0 and no further expiry occurs.
- R6: With auto-reload (bit 2) set, expiry loads the count from the period register, and counting goes on to expire again after another period*(S+1) cycles.
- R7: The interrupt output equals the flag. A control write with bit 3 = 1 clears the flag, a control write with bit 3 = 0 leaves it unchanged, and an expiry in the same cycle as a clearing write sets the flag.
- R8: Writing 0 to control stops the count at its current value, and the interrupt stays low while stopped.
- R9: A count write takes effect on the next edge and overrides a decrement due in that cycle.
- R10: Reads of any offset other than the four mapped ones return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, registered on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request, high while the expiry flag is set |

## Verification
The hardest cases to reach are collisions in a single cycle: a count write that lands on the cycle a decrement is due, and a flag clear that lands while a reload timer keeps running. Both depend on the exact phase of the prescaler. The bench reaches them by starting the timer with a known control write and counting edges from it, using scale 0 so that every cycle is a tick. It can then place the colliding write on a predicted edge and compare the read-back count and flag against the values the requirements give.

// File: rtl/ctimer_pkg.sv
// Package ctimer_pkg: register offsets, control bit positions and the
// control word type shared by the timer modules.
package ctimer_pkg;
    localparam int unsigned OFS_CTRL   = 0;
    localparam int unsigned OFS_PERIOD = 4;
    localparam int unsigned OFS_SCALE  = 8;
    localparam int unsigned OFS_COUNT  = 12;

    localparam int unsigned CB_PWR    = 0;
    localparam int unsigned CB_EN     = 1;
    localparam int unsigned CB_RELOAD = 2;
    localparam int unsigned CB_FLAG   = 3;

    typedef struct packed {
        logic flag;
        logic reload;
        logic en;
        logic pwr;
    } ctrl_t;
endpackage

// File: rtl/ctimer_regs.sv
// Module ctimer_regs: bus decode, control/period/scale storage, the sticky
// expiry flag and the read-back multiplexer.
// Assumes a single-cycle write strobe and combinational reads; the count
// register itself lives in ctimer_count and is only written from here.
module ctimer_regs
    import ctimer_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] count_i,
    input  logic              expire_i,
    output ctrl_t             ctrl_o,
    output logic [DATA_W-1:0] period_o,
    output logic [DATA_W-1:0] scale_o,
    output logic              cnt_we_o
);
    logic  sel_ctrl, sel_period, sel_scale, sel_count;
    ctrl_t ctrl_q;
    logic  [DATA_W-1:0] period_q, scale_q;

    // Address decode of the four mapped offsets.
    always_comb begin
        sel_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
        sel_period = (bus_addr == ADDR_W'(OFS_PERIOD));
        sel_scale  = (bus_addr == ADDR_W'(OFS_SCALE));
        sel_count  = (bus_addr == ADDR_W'(OFS_COUNT));
    end

    // Control bits: written directly; flag set by expiry, cleared by write-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (bus_we && sel_ctrl) begin
                ctrl_q.pwr    <= bus_wdata[CB_PWR];
                ctrl_q.en     <= bus_wdata[CB_EN];
                ctrl_q.reload <= bus_wdata[CB_RELOAD];
            end
            if (expire_i)
                ctrl_q.flag <= 1'b1;
            else if (bus_we && sel_ctrl && bus_wdata[CB_FLAG])
                ctrl_q.flag <= 1'b0;
        end
    end

    // Period and scale storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            scale_q  <= '0;
        end else begin
            if (bus_we && sel_period) period_q <= bus_wdata;
            if (bus_we && sel_scale)  scale_q  <= bus_wdata;
        end
    end

    // Read-back multiplexer; unmapped offsets return zero.
    always_comb begin
        if (sel_ctrl)        bus_rdata = DATA_W'(ctrl_q);
        else if (sel_period) bus_rdata = period_q;
        else if (sel_scale)  bus_rdata = scale_q;
        else if (sel_count)  bus_rdata = count_i;
        else                 bus_rdata = '0;
    end

    assign ctrl_o   = ctrl_q;
    assign period_o = period_q;
    assign scale_o  = scale_q;
    assign cnt_we_o = bus_we && sel_count;

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.flag && !(bus_we && sel_ctrl && bus_wdata[CB_FLAG])) |=> ctrl_q.flag);

    assert_flag_only_on_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.flag && !expire_i) |=> !ctrl_q.flag);

    assert_unmapped_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !sel_ctrl && !sel_period && !sel_scale && !sel_count && !expire_i)
        |=> ($stable(period_q) && $stable(scale_q) && $stable(ctrl_q)));
endmodule

// File: rtl/ctimer_prescale.sv
// Module ctimer_prescale: divides the clock by scale+1 while running.
// Assumes run drops whenever the timer is off; the phase restarts at zero
// each time run rises, so the first tick comes scale+1 cycles later.
module ctimer_prescale #(
    parameter int SCALE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic               tick_o
);
    logic [SCALE_W-1:0] psc_q;

    // Tick when the phase counter has reached the programmed ratio.
    assign tick_o = run_i && (psc_q >= scale_i);

    // Phase counter: held at zero when idle, wraps on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            psc_q <= '0;
        else if (!run_i || tick_o)
            psc_q <= '0;
        else
            psc_q <= psc_q + SCALE_W'(1);
    end

    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (!tick_o || scale_i == '0));
endmodule

// File: rtl/ctimer_count.sv
// Module ctimer_count: the down counter, expiry detection and reload.
// Assumes tick_i is a one-cycle strobe; a count write has priority over
// both a decrement and an expiry in the same cycle.
module ctimer_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             we_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_q;

    // Expiry: a tick that would take the count from one to zero.
    assign expire_o = tick_i && !we_i && (count_q == ONE);

    // Count update: write, then reload/stop on expiry, then decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (we_i)
            count_q <= wdata_i;
        else if (expire_o)
            count_q <= reload_i ? period_i : '0;
        else if (tick_i && count_q != '0)
            count_q <= count_q - ONE;
    end

    assign count_o = count_q;

    assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !we_i) |=> $stable(count_q));

    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !we_i && count_q > ONE) |=> (count_q == $past(count_q) - ONE));

    assert_reload_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && reload_i) |=> (count_q == $past(period_i)));

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (count_q == $past(wdata_i)));
endmodule

// File: rtl/ctimer_top.sv
// Module ctimer_top: memory-mapped countdown timer. Ties the register
// bank, prescaler and counter together; runs when power and enable are set.
// Assumes a synchronous bus with combinational reads.
module ctimer_top
    import ctimer_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] period, scale, count;
    logic              cnt_we, tick, expire, run;

    // Counting is allowed only with both power and enable bits on.
    assign run = ctrl.pwr && ctrl.en;
    assign irq = ctrl.flag;

    ctimer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .count_i(count), .expire_i(expire),
        .ctrl_o(ctrl), .period_o(period), .scale_o(scale), .cnt_we_o(cnt_we)
    );

    ctimer_prescale #(.SCALE_W(DATA_W)) psc_i (
        .clk(clk), .rst_n(rst_n), .run_i(run), .scale_i(scale), .tick_o(tick)
    );

    ctimer_count #(.CNT_W(DATA_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .we_i(cnt_we),
        .wdata_i(bus_wdata), .reload_i(ctrl.reload), .period_i(period),
        .count_o(count), .expire_o(expire)
    );

    assert_tick_needs_power_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (ctrl.pwr && ctrl.en));
endmodule

// File: tb/ctimer_top_tb_top.sv
// Bench ctimer_top_tb_top: directed scenarios, one task each, self-checking.
module ctimer_top_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    ctimer_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Write spanning exactly one rising edge; called and returning at a negedge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int a = 0; a < 16; a += 4) begin
            rd(4'(a), v);
            chk("R1 reset register", v, 32'h0);
        end
        chk("R1 reset irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        wr(4'h4, 32'h1234_5678);
        wr(4'h8, 32'h0000_0055);
        wr(4'hC, 32'hCAFE_0001);
        wr(4'h0, 32'hFFFF_FFF5); // power + reload, enable off
        rd(4'h4, v); chk("R2 period readback", v, 32'h1234_5678);
        rd(4'h8, v); chk("R2 scale readback", v, 32'h0000_0055);
        rd(4'hC, v); chk("R2 count readback", v, 32'hCAFE_0001);
        rd(4'h0, v); chk("R2 control readback", v, 32'h0000_0005);
        wr(4'h0, 32'h0000_0008);
    endtask

    task automatic t_gate;
        logic [31:0] v;
        wr(4'h8, 32'h0);
        wr(4'hC, 32'd5);
        wr(4'h0, 32'h2); // enable without power
        wait_cyc(4);
        rd(4'hC, v); chk("R3 enable only holds count", v, 32'd5);
        wr(4'h0, 32'h1); // power without enable
        wait_cyc(4);
        rd(4'hC, v); chk("R3 power only holds count", v, 32'd5);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_scale(input int s);
        logic [31:0] v;
        int n;
        n = 2 * (s + 1);
        wr(4'h8, 32'(s));
        wr(4'hC, 32'd2);
        wr(4'h0, 32'h3);
        wait_cyc(n - 1);
        rd(4'hC, v); chk("R4 count one edge before expiry", v, 32'd1);
        chk("R4 irq low before expiry", {31'b0, irq}, 32'h0);
        wait_cyc(1);
        rd(4'h0, v); chk("R5 control after expiry", v, 32'h0000_000B);
        chk("R7 irq follows flag", {31'b0, irq}, 32'h1);
        rd(4'hC, v); chk("R5 count at zero", v, 32'd0);
        wait_cyc(3 * (s + 1));
        rd(4'hC, v); chk("R5 count rests at zero", v, 32'd0);
        wr(4'h0, 32'h3); // write with bit3 = 0 keeps flag
        rd(4'h0, v); chk("R7 flag kept by write of 0 to bit3", v, 32'h0000_000B);
        wr(4'h0, 32'h8);
        rd(4'h0, v); chk("R7 flag cleared by write-1", v, 32'h0);
        chk("R7 irq low after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_reload;
        logic [31:0] v;
        wr(4'h8, 32'h0);
        wr(4'h4, 32'd3);
        wr(4'hC, 32'd2);
        wr(4'h0, 32'h7);
        wait_cyc(2);
        rd(4'hC, v); chk("R6 reloaded from period", v, 32'd3);
        chk("R6 irq after first expiry", {31'b0, irq}, 32'h1);
        wr(4'h0, 32'hF); // clear flag while running on
        rd(4'hC, v); chk("R6 counting continues", v, 32'd2);
        chk("R7 clear while running", {31'b0, irq}, 32'h0);
        wait_cyc(1);
        chk("R6 irq low before second expiry", {31'b0, irq}, 32'h0);
        wait_cyc(1);
        chk("R6 second expiry", {31'b0, irq}, 32'h1);
        rd(4'hC, v); chk("R6 reloaded again", v, 32'd3);
        wr(4'h0, 32'h8);
    endtask

    task automatic t_stop;
        logic [31:0] v;
        wr(4'h8, 32'h0);
        wr(4'hC, 32'd10);
        wr(4'h0, 32'h3);
        wait_cyc(2);
        rd(4'hC, v); chk("R8 counting before stop", v, 32'd8);
        wr(4'h0, 32'h0);
        rd(4'hC, v); chk("R8 last decrement on stop edge", v, 32'd7);
        wait_cyc(5);
        rd(4'hC, v); chk("R8 count frozen after stop", v, 32'd7);
        chk("R8 irq low while stopped", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_override;
        logic [31:0] v;
        wr(4'h8, 32'h0);
        wr(4'hC, 32'd10);
        wr(4'h0, 32'h3);
        wait_cyc(1);
        wr(4'hC, 32'd20); // tick is active on this edge
        rd(4'hC, v); chk("R9 write overrides decrement", v, 32'd20);
        wait_cyc(1);
        rd(4'hC, v); chk("R9 decrement resumes", v, 32'd19);
        wr(4'hC, 32'd1);
        rd(4'hC, v); chk("R9 write of one", v, 32'd1);
        wr(4'hC, 32'd5); // collides with the expiring tick
        chk("R9 write suppresses expiry", {31'b0, irq}, 32'h0);
        wr(4'h0, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(4'h4, 32'hAAAA_0001);
        wr(4'h8, 32'h0000_0007);
        wr(4'hC, 32'h0000_0042);
        wr(4'h0, 32'h0000_0005);
        for (int a = 0; a < 16; a++) begin
            if ((a % 4) != 0) wr(4'(a), 32'hFFFF_FFFF);
        end
        rd(4'h2, v); chk("R10 unmapped read zero", v, 32'h0);
        rd(4'hF, v); chk("R10 unmapped read zero high", v, 32'h0);
        rd(4'h4, v); chk("R10 period untouched", v, 32'hAAAA_0001);
        rd(4'h8, v); chk("R10 scale untouched", v, 32'h0000_0007);
        rd(4'hC, v); chk("R10 count untouched", v, 32'h0000_0042);
        rd(4'h0, v); chk("R10 control untouched", v, 32'h0000_0005);
        chk("R10 irq untouched", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_map();
        t_gate();
        t_scale(1);
        t_scale(3);
        t_reload();
        t_stop();
        t_override();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule